// File: doc/BRIEF.md
# Floating-Point Reciprocal Exponent Unit

This block computes a coarse reciprocal scale factor for a floating-point operand in half, single or double precision. For any ordinary operand it keeps the sign, replaces the exponent field with its bitwise complement and clears the fraction. Software typically uses the result to pre-scale a value before an iterative divide or square-root sequence. Zero and subnormal operands get a fixed exponent, the largest finite one. Infinities map to a signed zero.

NaN operands follow the usual propagation rules. A signalling NaN is quieted and raises the invalid-operation flag. A quiet NaN passes through unchanged. When the default-NaN control is set, every NaN becomes the format's canonical NaN. A flush control treats subnormal operands as signed zeros. Because the fraction is discarded, this leaves the result unchanged. The datapath is combinational and ends in one output register, so the result appears one clock after the operand is presented.

Top module: `frecpx_unit`

## Requirements
- R1: For a non-NaN operand, the result sign equals the operand sign and every result fraction bit is zero.
- R2: The exponent field sits at bits 14:10 (half), 30:23 (single) or 62:52 (double), with the fraction below it. For a non-NaN operand whose exponent is neither zero nor all ones, the result exponent is the bitwise complement of the operand exponent. An infinity (exponent all ones, fraction zero) therefore gives a signed zero.
- R3: When the operand exponent field is zero (a zero or a subnormal), the result exponent is the all-ones pattern minus one: 0x1E, 0xFE or 0x7FE. This holds whether the flush control `flush_en` is set or clear.
- R4: A signalling NaN is a NaN whose top fraction bit is 0. When `dflt_nan_en` is clear, it produces the same bits with the top fraction bit set and `invalid` high for that result.
- R5: A quiet NaN has its top fraction bit at 1. When `dflt_nan_en` is clear, it is returned bit for bit with `invalid` low.
- R6: When `dflt_nan_en` is set, any NaN operand yields the default NaN. This is sign 0, exponent all ones, and only the top fraction bit set: 0x7E00, 0x7FC00000 or 0x7FF8000000000000. `invalid` is still high exactly for a signalling NaN.
- R7: `fmt` encodes 0 as half, 1 as single, 2 as double, and 3 is handled as double. Operand bits above the selected width are ignored, and result bits above it are zero.
- R8: `result` and `invalid` are registered. They reflect the operand, format and controls sampled at the previous rising clock edge. While `rst_n` is low at an edge, both become zero.
- R9: `invalid` is high only for a signalling NaN operand. Every other operand leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt | input | 2 | Precision select: 0 half, 1 single, 2 or 3 double |
| opnd | input | 64 | Operand, right-aligned for half and single |
| dflt_nan_en | input | 1 | Replace every NaN result by the default NaN |
| flush_en | input | 1 | Treat subnormal operands as signed zero |
| result | output | 64 | Reciprocal exponent result, zero-extended |
| invalid | output | 1 | Invalid-operation flag for the result |

## Verification
The bench targets the exponent-field boundaries in all three formats. These are an exponent of zero with and without fraction bits, the all-ones exponent with zero, quiet and signalling fractions, and the value one below all ones. A design that complemented a zero exponent would return an infinity instead of the largest finite exponent. A design that treated an infinity as a NaN would raise `invalid` or return a NaN where a signed zero belongs. The NaN cases are run with the default-NaN control in both states. This catches a quieting step that disturbs the payload or sign, and a default-NaN path that forgets to keep the invalid flag. Random operands are padded with junk above the selected width, so a format mux that leaks upper bits is exposed. The reserved format code is driven to confirm it behaves as double.

// File: rtl/frecpx_pkg.sv
// Package: shared widths and the precision encoding for the
// reciprocal exponent unit. Assumes IEEE-style binary layouts.
package frecpx_pkg;

    localparam int DATA_W   = 64;
    localparam int N_FMT    = 3;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_SINGLE = 2'd1,
        FMT_DOUBLE = 2'd2,
        FMT_RSVD   = 2'd3
    } prec_e;

    // Exponent and fraction widths per lane index (0 half, 1 single, 2 double)
    function automatic int exp_width(input int idx);
        return (idx == 0) ? 5 : (idx == 1) ? 8 : 11;
    endfunction

    function automatic int frac_width(input int idx);
        return (idx == 0) ? 10 : (idx == 1) ? 23 : 52;
    endfunction

endpackage

// File: rtl/frecpx_classify.sv
// Module: frecpx_classify
// Splits one operand of a given layout into fields and classifies it.
// Assumes sign at the top bit, exponent below it, fraction at the bottom.
// Flushing only changes the class of a subnormal, since no fraction
// bit reaches the result of a non-NaN operand.
module frecpx_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0]      x,
    input  logic              flush_en,
    output logic              sign,
    output logic [EXP_W-1:0]  expo,
    output logic [FRAC_W-1:0] frac,
    output logic              is_nan,
    output logic              is_snan,
    output logic              is_zero_cls,
    output logic              is_subn_kept
);

    logic exp_all_ones;
    logic exp_all_zero;
    logic frac_nonzero;

    // Field extraction and class detection
    always_comb begin
        sign         = x[W-1];
        expo         = x[W-2:FRAC_W];
        frac         = x[FRAC_W-1:0];
        exp_all_ones = &expo;
        exp_all_zero = ~|expo;
        frac_nonzero = |frac;
        is_nan       = exp_all_ones & frac_nonzero;
        is_snan      = is_nan & ~frac[FRAC_W-1];
        is_zero_cls  = exp_all_zero & (~frac_nonzero | flush_en);
        is_subn_kept = exp_all_zero & frac_nonzero & ~flush_en;
    end

endmodule

// File: rtl/frecpx_lane.sv
// Module: frecpx_lane
// Produces the reciprocal exponent result for one precision.
// Assumes the caller selects which lane's result is used.
module frecpx_lane #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] x,
    input  logic         dflt_nan_en,
    input  logic         flush_en,
    output logic [W-1:0] res,
    output logic         inv
);

    localparam logic [EXP_W-1:0]  EXP_ONES  = '1;
    localparam logic [EXP_W-1:0]  EXP_MAXF  = EXP_ONES - 1'b1;
    localparam logic [FRAC_W-1:0] QBIT      = {1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [FRAC_W-1:0] FRAC_ZERO = '0;

    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic              is_nan;
    logic              is_snan;
    logic              is_zero_cls;
    logic              is_subn_kept;

    frecpx_classify #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) u_cls (
        .x            (x),
        .flush_en     (flush_en),
        .sign         (sign),
        .expo         (expo),
        .frac         (frac),
        .is_nan       (is_nan),
        .is_snan      (is_snan),
        .is_zero_cls  (is_zero_cls),
        .is_subn_kept (is_subn_kept)
    );

    // Result composition: NaN handling first, then exponent substitution
    always_comb begin
        inv = is_snan;
        if (is_nan) begin
            if (dflt_nan_en) begin
                res = {1'b0, EXP_ONES, QBIT};
            end else begin
                res = {sign, expo, frac | QBIT};
            end
        end else if (is_zero_cls | is_subn_kept) begin
            res = {sign, EXP_MAXF, FRAC_ZERO};
        end else begin
            res = {sign, ~expo, FRAC_ZERO};
        end
    end

endmodule

// File: rtl/frecpx_unit.sv
// Module: frecpx_unit (top)
// Reciprocal exponent unit for half, single and double precision.
// Three lanes work in parallel, a format mux picks one, and a single
// output register holds the result. Assumes narrow operands are
// right-aligned in opnd. Reset is synchronous, active low.
module frecpx_unit
    import frecpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt,
    input  logic [DATA_W-1:0] opnd,
    input  logic              dflt_nan_en,
    input  logic              flush_en,
    output logic [DATA_W-1:0] result,
    output logic              invalid
);

    logic [DATA_W-1:0] lane_res [N_FMT];
    logic [N_FMT-1:0]  lane_inv;
    logic [DATA_W-1:0] sel_res;
    logic              sel_inv;

    for (genvar g = 0; g < N_FMT; g++) begin : g_lane
        localparam int EW = exp_width(g);
        localparam int FW = frac_width(g);
        localparam int LW = 1 + EW + FW;

        logic [LW-1:0] lr;

        frecpx_lane #(
            .EXP_W  (EW),
            .FRAC_W (FW)
        ) u_lane (
            .x           (opnd[LW-1:0]),
            .dflt_nan_en (dflt_nan_en),
            .flush_en    (flush_en),
            .res         (lr),
            .inv         (lane_inv[g])
        );

        assign lane_res[g] = DATA_W'(lr);
    end

    // Format select; the reserved code falls back to double
    always_comb begin
        unique case (prec_e'(fmt))
            FMT_HALF:   begin sel_res = lane_res[0]; sel_inv = lane_inv[0]; end
            FMT_SINGLE: begin sel_res = lane_res[1]; sel_inv = lane_inv[1]; end
            default:    begin sel_res = lane_res[2]; sel_inv = lane_inv[2]; end
        endcase
    end

    // Output register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            invalid <= 1'b0;
        end else begin
            result  <= sel_res;
            invalid <= sel_inv;
        end
    end

endmodule

// File: rtl/frecpx_unit_chk.sv
// Module: frecpx_unit_chk
// Assertion checker bound to frecpx_unit. It registers the inputs
// itself and relates them to the registered outputs one cycle later.
module frecpx_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  fmt,
    input logic [63:0] opnd,
    input logic        dflt_nan_en,
    input logic [63:0] result,
    input logic        invalid
);

    logic [1:0]  p_fmt;
    logic [63:0] p_x;
    logic        p_dn;
    logic        p_ok;
    logic        p_rst;

    // Capture inputs of the previous edge
    always_ff @(posedge clk) begin
        p_fmt <= fmt;
        p_x   <= opnd;
        p_dn  <= dflt_nan_en;
        p_ok  <= rst_n;
        p_rst <= !rst_n;
    end

    logic        in_sign, out_sign;
    logic [10:0] in_exp, out_exp, ones;
    logic [51:0] in_frac, out_frac, qbit;
    logic        upper_zero;

    // Field decode of operand and result per previous format
    always_comb begin
        case (p_fmt)
            2'd0: begin
                in_sign = p_x[15];     in_exp = {6'd0, p_x[14:10]};  in_frac = {42'd0, p_x[9:0]};
                out_sign = result[15]; out_exp = {6'd0, result[14:10]}; out_frac = {42'd0, result[9:0]};
                ones = 11'h1F; qbit = 52'd1 << 9; upper_zero = (result[63:16] == '0);
            end
            2'd1: begin
                in_sign = p_x[31];     in_exp = {3'd0, p_x[30:23]};  in_frac = {29'd0, p_x[22:0]};
                out_sign = result[31]; out_exp = {3'd0, result[30:23]}; out_frac = {29'd0, result[22:0]};
                ones = 11'hFF; qbit = 52'd1 << 22; upper_zero = (result[63:32] == '0);
            end
            default: begin
                in_sign = p_x[63];     in_exp = p_x[62:52];  in_frac = p_x[51:0];
                out_sign = result[63]; out_exp = result[62:52]; out_frac = result[51:0];
                ones = 11'h7FF; qbit = 52'd1 << 51; upper_zero = 1'b1;
            end
        endcase
    end

    logic in_nan, in_snan, in_mid;
    assign in_nan  = (in_exp == ones) && (in_frac != '0);
    assign in_snan = in_nan && ((in_frac & qbit) == '0);
    assign in_mid  = (in_exp != '0) && (in_exp != ones);

    p_sign_frac_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && !in_nan) |-> (out_sign == in_sign && out_frac == '0));

    p_exp_cmpl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && in_mid) |-> ((out_exp ^ in_exp) == ones));

    p_zero_exp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && in_exp == '0) |-> (out_exp == ones - 11'd1));

    p_dflt_nan_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && p_dn && in_nan) |-> (!out_sign && out_exp == ones && out_frac == qbit));

    p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        p_ok |-> upper_zero);

    p_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        p_rst |-> (result == '0 && !invalid));

    p_invalid_snan_r9: assert property (@(posedge clk) disable iff (!rst_n)
        p_ok |-> (invalid == in_snan));

endmodule

bind frecpx_unit frecpx_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fmt         (fmt),
    .opnd        (opnd),
    .dflt_nan_en (dflt_nan_en),
    .result      (result),
    .invalid     (invalid)
);

// File: tb/frecpx_unit_bench.sv
// Bench: directed corners plus seeded random operands, each compared
// with a reference computed from the requirements one clock later.
module frecpx_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic [63:0] opnd = '0;
    logic        dflt_nan_en = 1'b0;
    logic        flush_en = 1'b0;
    logic [63:0] result;
    logic        invalid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    frecpx_unit u_frecpx_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .fmt         (fmt),
        .opnd        (opnd),
        .dflt_nan_en (dflt_nan_en),
        .flush_en    (flush_en),
        .result      (result),
        .invalid     (invalid)
    );

    // Reference: {invalid, result} from the requirement text
    function automatic logic [64:0] ref_model(input logic [1:0] f, input logic [63:0] xin,
                                             input logic dn);
        int e, fr, w;
        logic [63:0] x, ones, ex, fv, qb, r, ne;
        logic inv;
        e  = (f == 2'd0) ? 5  : (f == 2'd1) ? 8  : 11;
        fr = (f == 2'd0) ? 10 : (f == 2'd1) ? 23 : 52;
        w  = 1 + e + fr;
        x  = (w == 64) ? xin : (xin & ((64'd1 << w) - 64'd1));
        ones = (64'd1 << e) - 64'd1;
        ex = (x >> fr) & ones;
        fv = x & ((64'd1 << fr) - 64'd1);
        qb = 64'd1 << (fr - 1);
        inv = 1'b0;
        if (ex == ones && fv != 0) begin
            inv = ((fv & qb) == 0);
            r = dn ? ((ones << fr) | qb) : (x | qb);
        end else begin
            ne = (ex == 0) ? (ones - 64'd1) : (~ex & ones);
            r = (((x >> (w - 1)) & 64'd1) << (w - 1)) | (ne << fr);
        end
        return {inv, r};
    endfunction

    task automatic run_one(input logic [1:0] f, input logic [63:0] x, input logic dn,
                           input logic fz, input string tag);
        logic [64:0] exp_v;
        @(negedge clk);
        fmt = f; opnd = x; dflt_nan_en = dn; flush_en = fz;
        exp_v = ref_model(f, x, dn);
        @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if ({invalid, result} !== exp_v) begin
            n_bad++;
            $display("FAIL %s fmt=%0d x=%h dn=%0b fz=%0b: got inv=%0b res=%h, expected inv=%0b res=%h",
                     tag, f, x, dn, fz, invalid, result, exp_v[64], exp_v[63:0]);
        end
    endtask

    task automatic check_lit(input logic [63:0] exp_r, input logic exp_i, input string tag);
        n_cmp++;
        if (result !== exp_r || invalid !== exp_i) begin
            n_bad++;
            $display("FAIL %s: got inv=%0b res=%h, expected inv=%0b res=%h",
                     tag, invalid, result, exp_i, exp_r);
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5EED_0F17;
        void'($urandom(seed));
        opnd = 64'hFFFF_FFFF_FFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_lit(64'd0, 1'b0, "R8 reset state");
        rst_n = 1'b1;

        // Literal spot checks (R2, R3, R4, R5, R6)
        run_one(2'd0, 64'h3C00, 0, 0, "R2 half one");
        check_lit(64'h4000, 1'b0, "R2 half one literal");
        run_one(2'd0, 64'h0000, 0, 0, "R3 half zero");
        check_lit(64'h7800, 1'b0, "R3 half zero literal");
        run_one(2'd1, 64'h0000_0000_8000_0001, 0, 1, "R3 single neg subnormal flushed");
        check_lit(64'h0000_0000_FF00_0000, 1'b0, "R3 single flushed literal");
        run_one(2'd1, 64'h0000_0000_8000_0001, 0, 0, "R3 single neg subnormal kept");
        run_one(2'd2, 64'h3FF0_0000_0000_0000, 0, 0, "R2 double one");
        check_lit(64'h4000_0000_0000_0000, 1'b0, "R2 double one literal");
        run_one(2'd0, 64'h7C01, 0, 0, "R4 half snan");
        check_lit(64'h7E01, 1'b1, "R4 half snan literal");
        run_one(2'd1, 64'h0000_0000_FFC1_2345, 0, 0, "R5 single qnan");
        check_lit(64'h0000_0000_FFC1_2345, 1'b0, "R5 single qnan literal");
        run_one(2'd2, 64'hFFF0_0000_0000_0007, 1, 0, "R6 double snan default");
        check_lit(64'h7FF8_0000_0000_0000, 1'b1, "R6 double snan default literal");
        run_one(2'd1, 64'h0000_0000_FFC0_0001, 1, 0, "R6 single qnan default");
        check_lit(64'h0000_0000_7FC0_0000, 1'b0, "R6 single qnan default literal");
        run_one(2'd0, 64'hFC00, 0, 0, "R2 half neg inf");
        check_lit(64'h8000, 1'b0, "R2 half inf literal");
        run_one(2'd0, 64'h7BFF, 0, 0, "R2 half max exponent");
        run_one(2'd0, 64'hABCD_0000_0000_3C00, 0, 0, "R7 half upper junk");
        check_lit(64'h4000, 1'b0, "R7 half upper junk literal");
        run_one(2'd3, 64'h3FF0_0000_0000_0000, 0, 0, "R7 reserved fmt as double");
        check_lit(64'h4000_0000_0000_0000, 1'b0, "R7 reserved literal");
        run_one(2'd1, 64'h1234_5678_0000_0000, 0, 0, "R7 single upper junk zero");

        // Random with field biasing (R1, R2, R3, R4, R5, R6, R7, R9)
        for (int i = 0; i < 4000; i++) begin
            logic [63:0] x;
            logic [1:0]  f;
            int e, fr, sel;
            f  = 2'($urandom_range(0, 3));
            x  = {$urandom, $urandom};
            e  = (f == 2'd0) ? 5  : (f == 2'd1) ? 8  : 11;
            fr = (f == 2'd0) ? 10 : (f == 2'd1) ? 23 : 52;
            sel = $urandom_range(0, 5);
            if (sel == 0) x = x & ~(((64'd1 << e) - 64'd1) << fr);
            if (sel == 1) x = x | (((64'd1 << e) - 64'd1) << fr);
            if (sel == 2) x = (x | (((64'd1 << e) - 64'd1) << fr)) & ~(64'd1 << (fr - 1));
            if (sel == 3) x = x & ~((64'd1 << fr) - 64'd1);
            run_one(f, x, 1'($urandom), 1'($urandom), "R1/R2/R3/R4/R5/R6/R7/R9 random");
        end

        // Reset mid-run (R8)
        @(negedge clk);
        opnd = 64'h7C01; fmt = 2'd0; rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_lit(64'd0, 1'b0, "R8 reset after activity");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule